// File: doc/BRIEF.md
# Burst SRAM address sequencer

This block is the address and cycle-control front end of a synchronous burst memory. On every rising clock edge it samples two active-low address strobes (a processor strobe and a controller strobe), an active-low advance input, three chip enables (one master active-low, one secondary active-high, one secondary active-low), a static burst-order select and a 19-bit external address. From these it classifies the edge as a deselect, a new burst load, an advance or a hold. It then presents the current word address and an active flag to the storage array and datapath.

A burst covers four words. The upper address bits stay fixed, and the two low bits step through either an XOR (interleaved) order or a modulo-4 add (linear) order. The order is chosen by the select pin. The write enables do not change the address sequencing: a write burst advances under exactly the same conditions as a read burst. Reset is synchronous and active high.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is high on an edge, the block ends that edge with `active`=0, `kind`=0 (deselect) and `word_addr`=0.
- R2: A processor strobe (`adsp_n`=0) with the master enable active (`ce0_n`=0) and both secondary enables active (`ce1`=1, `ce2_n`=0) loads `ext_addr`. After that edge, `word_addr` equals the sampled address, `active`=1 and `kind`=1 (load).
- R3: With `ce0_n`=1, the processor strobe is ignored. If `adsc_n`=1 on that edge, the edge is treated as if no strobe were present: an active burst reports `kind`=3 (hold) and keeps its address, even when `adv_n`=0.
- R4: A controller strobe (`adsc_n`=0) with `adsp_n`=1 and all three enables active loads `ext_addr` in the same way as R2, with `kind`=1.
- R5: On an edge where a qualifying strobe is present (a processor strobe with `ce0_n`=0, or any controller strobe), a single inactive chip enable gives `active`=0 and `kind`=0. A controller strobe with `ce0_n`=1 also gives this result.
- R6: On a load edge the advance input has no effect. The first word of the burst is always the loaded address.
- R7: With both strobes high, `adv_n`=0 and the block active, the low two address bits move to the next burst position and `kind`=2 (advance).
- R8: With both strobes high, `adv_n`=1 and the block active, `word_addr` is held and `kind`=3.
- R9: With `mode_xor`=1, the low bits for beat count c (0..3) equal the start bits XOR c. For example, start 01 gives 01, 00, 11, 10.
- R10: With `mode_xor`=0, the low bits for beat count c equal the start bits plus c, modulo 4. For example, start 01 gives 01, 10, 11, 00.
- R11: Bits 18..2 of `word_addr` never change during a burst. After four advances, the low bits wrap back to the start value.
- R12: With no strobe present and the block not active, `kind`=0 and `active` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| adsp_n | input | 1 | Processor address strobe, active low, gated by `ce0_n` |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce0_n | input | 1 | Master chip enable, active low |
| ce1 | input | 1 | Secondary chip enable, active high |
| ce2_n | input | 1 | Secondary chip enable, active low |
| mode_xor | input | 1 | Burst order: 1 selects interleaved (XOR), 0 selects linear (add) |
| ext_addr | input | 19 | External word address |
| word_addr | output | 19 | Current burst word address |
| active | output | 1 | Device selected and a burst is in progress |
| kind | output | 2 | Last edge class: 0 deselect, 1 load, 2 advance, 3 hold |

## Verification
The assertions assume that `mode_xor` is held constant for the length of a burst. The bench changes it only immediately before a load edge. All other inputs may take any value on any edge. The bench sweeps all 32 combinations of the two strobes and three enables, starting each time from a freshly loaded burst. It also runs every start position in both orders, with the advance input asserted on the load edge and with hold edges mixed into the burst.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adsp_n,
  input  logic          adsc_n,
  input  logic          adv_n,
  input  logic          ce0_n,
  input  logic          ce1,
  input  logic          ce2_n,
  input  logic          mode_xor,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] word_addr,
  output logic          active,
  output logic [1:0]    kind
);
  localparam int UW = AW - 2;
  localparam logic [1:0] K_DESEL = 2'd0, K_LOAD = 2'd1, K_ADV = 2'd2, K_HOLD = 2'd3;

  logic [UW-1:0] upper;
  logic [1:0]    start, beat;

  wire strobe  = (!adsp_n && !ce0_n) || !adsc_n;
  wire all_en  = !ce0_n && ce1 && !ce2_n;
  wire step_ok = adsp_n && adsc_n && !adv_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      upper  <= '0;
      start  <= '0;
      beat   <= '0;
      active <= 1'b0;
      kind   <= K_DESEL;
    end else if (strobe) begin
      if (all_en) begin
        upper  <= ext_addr[AW-1:2];
        start  <= ext_addr[1:0];
        beat   <= '0;
        active <= 1'b1;
        kind   <= K_LOAD;
      end else begin
        active <= 1'b0;
        kind   <= K_DESEL;
      end
    end else if (!active) begin
      kind <= K_DESEL;
    end else if (step_ok) begin
      beat <= beat + 2'd1;
      kind <= K_ADV;
    end else begin
      kind <= K_HOLD;
    end
  end

  assign word_addr = {upper, mode_xor ? (start ^ beat) : (start + beat)};

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    kind == K_LOAD |-> (beat == 2'd0 && upper == $past(ext_addr[AW-1:2]) && start == $past(ext_addr[1:0])));
  p_ce0_block_r3: assert property (@(posedge clk) disable iff (rst)
    $past(ce0_n && adsc_n) |-> kind != K_LOAD);
  p_desel_r5: assert property (@(posedge clk) disable iff (rst)
    kind == K_DESEL |-> !active);
  p_step_r7: assert property (@(posedge clk) disable iff (rst)
    kind == K_ADV |-> beat == $past(beat) + 2'd1);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    kind == K_HOLD |-> $stable(beat) && $stable(start));
  p_upper_r11: assert property (@(posedge clk) disable iff (rst)
    (kind == K_ADV || kind == K_HOLD) |-> $stable(upper));
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic ce0_n = 1'b1, ce1 = 1'b0, ce2_n = 1'b1, mode_xor = 1'b1;
  logic [18:0] ext_addr = '0;
  logic [18:0] word_addr;
  logic active;
  logic [1:0] kind;

  int checks = 0, fails = 0;
  logic        m_act = 1'b0;
  logic [16:0] m_up = '0;
  logic [1:0]  m_s = '0, m_c = '0, m_k = '0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.AW(19)) u_dut (
    .clk(clk), .rst(rst), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .mode_xor(mode_xor),
    .ext_addr(ext_addr), .word_addr(word_addr), .active(active), .kind(kind)
  );

  task automatic check(input string req, input logic [18:0] got, input logic [18:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic p, input logic c, input logic v, input logic e0,
                     input logic e1, input logic e2, input logic [18:0] a, input string req);
    logic strobe, en;
    logic [1:0] lo;
    @(negedge clk);
    adsp_n = p; adsc_n = c; adv_n = v; ce0_n = e0; ce1 = e1; ce2_n = e2; ext_addr = a;
    strobe = (!p && !e0) || !c;
    en = !e0 && e1 && !e2;
    if (strobe) begin
      if (en) begin m_k = 2'd1; m_act = 1'b1; m_up = a[18:2]; m_s = a[1:0]; m_c = 2'd0; end
      else begin m_k = 2'd0; m_act = 1'b0; end
    end else if (!m_act) m_k = 2'd0;
    else if (!v && p) begin m_k = 2'd2; m_c = m_c + 2'd1; end
    else m_k = 2'd3;
    @(posedge clk); #1;
    lo = mode_xor ? (m_s ^ m_c) : (m_s + m_c);
    check({req, " kind"}, {17'd0, kind}, {17'd0, m_k});
    check({req, " active"}, {18'd0, active}, {18'd0, m_act});
    if (m_act) check({req, " addr"}, word_addr, {m_up, lo});
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 active", {18'd0, active}, 19'd0);
    check("R1 kind", {17'd0, kind}, 19'd0);
    check("R1 addr", word_addr, 19'd0);
    @(negedge clk); rst = 1'b0;
    cyc(1, 1, 0, 1, 0, 1, 19'h7, "R12 idle");

    for (int i = 0; i < 32; i++) begin
      cyc(0, 1, 1, 0, 1, 0, 19'h2A5A6 + 19'(i), "R2 preload");
      cyc(i[0], i[1], 0, i[2], i[3], i[4], 19'h15A53 ^ 19'(i << 3),
          (i[2] && i[1]) ? "R3 blocked" : (!(i[0] && i[1]) ? "R5/R2/R4 strobe" : "R7 step"));
    end

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        @(negedge clk); mode_xor = m[0];
        cyc(1, 0, 0, 0, 1, 0, {17'h1C3A5 ^ 17'(s * 77), 2'(s)}, "R4 R6 load");
        for (int b = 0; b < 6; b++)
          cyc(1, 1, (b == 2) ? 1'b1 : 1'b0, 0, 1, 0, 19'h7FFFF,
              m[0] ? "R9 R11 xor" : "R10 R11 linear");
        cyc(0, 1, 0, 1, 1, 0, 19'h0, "R3 ce0 blocks");
        cyc(1, 1, 1, 0, 1, 0, 19'h0, "R8 hold");
      end
    end

    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R1 reset active", {18'd0, active}, 19'd0);
    check("R1 reset kind", {17'd0, kind}, 19'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule